// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block follows the low-power state of one processor core. A decoded halt (or monitor-wait) instruction puts the core into halt, and an active-low stop-clock pin puts it into stop-grant. Each of these two states has its own snoop sub-state. The block enters that sub-state while a cache snoop is serviced, then returns to the state it left. A break event (init, bus-init, interrupt, non-maskable interrupt, system-management interrupt or bus interrupt) ends a halt.

When extended halt is enabled and the core is not already at its lowest bus ratio, entering halt also lowers the operating point. The block saves the present voltage ID and ratio, then asks for the minimum ratio, then for the minimum voltage ID. Leaving halt reverses this. The voltage ID is restored first and the ratio second, and normal execution resumes only after both steps are done. Each step is a request that stays high until its done input arrives.

A synchronous soft reset forces normal execution from any state and abandons any voltage or ratio step in progress.

Top module: `pwr_stopclk_ctrl`

## Requirements
- R1: After `rst_ni` is low, or one cycle after `soft_rst_i` is high, `state_o` is 0 (normal). Both requests are low and `halt_cyc_o` is low, including when the reset lands in the middle of a restore.
- R2: In normal, with stop-clock not asserted, `halt_req_i` moves `state_o` to 1 (halt) on the next edge. `halt_cyc_o` is high for exactly that first cycle of halt.
- R3: In normal, `stpclk_ni` low moves `state_o` to 3 (stop-grant) and takes priority over `halt_req_i`. Stop-grant entered from normal returns to 0 when `stpclk_ni` goes high.
- R4: In halt, `snp_req_i` moves `state_o` to 2 (halt-snoop) with `snoop_svc_o` high until `snp_done_i`. The block then returns to 1.
- R5: In stop-grant, `snp_req_i` moves `state_o` to 4 (stop-grant-snoop) with `snoop_svc_o` high until `snp_done_i`. The block then returns to 3.
- R6: In a plain halt, any bit of `brk_i` returns `state_o` to 0 on the next edge. In stop-grant, `brk_i` has no effect.
- R7: In halt, `stpclk_ni` low moves to 3. Its later release returns to 1, not 0.
- R8: A snoop and a break in the same halt cycle: the snoop is served first (2, then 1), and the held break then returns the block to 0 one cycle after it is back in halt.
- R9: Entering halt with `ext_halt_en_i` high and `cur_ratio_i` not equal to `min_ratio_i` raises `ratio_req_o` with `ratio_val_o` = `min_ratio_i`. After `ratio_done_i`, it raises `vid_req_o` with `vid_val_o` = `min_vid_i`.
- R10: A break from an extended halt moves `state_o` to 5 (restoring) and raises `vid_req_o` with the saved voltage ID. After `vid_done_i`, it raises `ratio_req_o` with the saved ratio. After `ratio_done_i`, `state_o` returns to 0 on the same edge.
- R11: With extended halt disabled, or with `cur_ratio_i` equal to `min_ratio_i`, a halt issues no voltage or ratio request, and a break returns directly to 0.
- R12: Each request output stays high on every cycle until its done input is seen.
- R13: A break that arrives while the lowering steps are still running is held. It takes effect one cycle after the last lowering step completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous reset event, forces normal |
| ext_halt_en_i | input | 1 | Enables operating-point lowering in halt |
| halt_req_i | input | 1 | Decoded halt or monitor-wait pulse |
| stpclk_ni | input | 1 | Stop-clock request, active low |
| snp_req_i | input | 1 | Snoop request strobe |
| snp_done_i | input | 1 | Snoop serviced strobe |
| brk_i | input | BRK_W | Break event lines |
| cur_vid_i | input | VID_W | Present voltage ID |
| cur_ratio_i | input | RATIO_W | Present core-to-bus ratio |
| min_vid_i | input | VID_W | Minimum voltage ID |
| min_ratio_i | input | RATIO_W | Lowest supported ratio |
| vid_done_i | input | 1 | Voltage step complete |
| ratio_done_i | input | 1 | Ratio step complete |
| state_o | output | 3 | 0 normal, 1 halt, 2 halt-snoop, 3 stop-grant, 4 stop-grant-snoop, 5 restoring |
| halt_cyc_o | output | 1 | Halt bus-cycle strobe |
| snoop_svc_o | output | 1 | Snoop service enable |
| vid_req_o | output | 1 | Voltage ID change request |
| vid_val_o | output | VID_W | Requested voltage ID |
| ratio_req_o | output | 1 | Ratio change request |
| ratio_val_o | output | RATIO_W | Requested ratio |

## Verification
Every state is registered and shown directly on `state_o`, so a wrong transition is visible one edge after the input that caused it. A lost stop-grant origin appears when the pin is released, because the block returns to 0 instead of 1. A lost held break appears as the block staying in halt after the snoop completes. A sequencer that has the order wrong, or drops a request, is seen in the same cycle on the request pins and values, because these are decoded straight from the sequencer state. A wrongly saved operating point is seen on the first restore request.

// File: rtl/pwr_state_pkg.sv
`timescale 1ns/1ps
package pwr_state_pkg;
  typedef enum logic [2:0] {
    PS_RUN      = 3'd0,
    PS_HALT     = 3'd1,
    PS_HALT_SNP = 3'd2,
    PS_SGNT     = 3'd3,
    PS_SGNT_SNP = 3'd4,
    PS_RESTORE  = 3'd5
  } pstate_e;

  typedef enum logic [2:0] {
    SQ_IDLE      = 3'd0,
    SQ_LOW_RATIO = 3'd1,
    SQ_LOW_VID   = 3'd2,
    SQ_UP_VID    = 3'd3,
    SQ_UP_RATIO  = 3'd4
  } seq_e;
endpackage

// File: rtl/pwr_brk_track.sv
`timescale 1ns/1ps
module pwr_brk_track #(
  parameter int unsigned BRK_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic [BRK_W-1:0] brk_i,
  input  logic             arm_i,
  input  logic             clr_i,
  output logic             brk_now_o
);
  logic pend_q;
  logic brk_any;

  assign brk_any = |brk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pend_q <= 1'b0;
    else if (soft_rst_i || clr_i) pend_q <= 1'b0;
    else if (arm_i && brk_any)    pend_q <= 1'b1;
  end

  assign brk_now_o = brk_any | pend_q;

  // a break seen in halt and not consumed must stay visible
  p_held_break_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && brk_any && !clr_i && !soft_rst_i) |=> brk_now_o);
endmodule

// File: rtl/pwr_seq.sv
`timescale 1ns/1ps
module pwr_seq
  import pwr_state_pkg::*;
#(
  parameter int unsigned VID_W   = 8,
  parameter int unsigned RATIO_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               abort_i,
  input  logic               start_ent_i,
  input  logic               start_exit_i,
  input  logic [VID_W-1:0]   cur_vid_i,
  input  logic [RATIO_W-1:0] cur_ratio_i,
  input  logic [VID_W-1:0]   min_vid_i,
  input  logic [RATIO_W-1:0] min_ratio_i,
  input  logic               vid_done_i,
  input  logic               ratio_done_i,
  output logic               vid_req_o,
  output logic [VID_W-1:0]   vid_val_o,
  output logic               ratio_req_o,
  output logic [RATIO_W-1:0] ratio_val_o,
  output logic               busy_o,
  output logic               ext_o,
  output logic               exit_done_o
);
  seq_e               sq_q;
  logic               ext_q;
  logic [VID_W-1:0]   sv_vid_q;
  logic [RATIO_W-1:0] sv_ratio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q       <= SQ_IDLE;
      ext_q      <= 1'b0;
      sv_vid_q   <= '0;
      sv_ratio_q <= '0;
    end else if (abort_i) begin
      sq_q  <= SQ_IDLE;
      ext_q <= 1'b0;
    end else begin
      unique case (sq_q)
        SQ_IDLE: begin
          if (start_ent_i) begin
            sv_vid_q   <= cur_vid_i;
            sv_ratio_q <= cur_ratio_i;
            ext_q      <= 1'b1;
            sq_q       <= SQ_LOW_RATIO;
          end else if (start_exit_i && ext_q) begin
            sq_q <= SQ_UP_VID;
          end
        end
        SQ_LOW_RATIO: if (ratio_done_i) sq_q <= SQ_LOW_VID;
        SQ_LOW_VID:   if (vid_done_i)   sq_q <= SQ_IDLE;
        SQ_UP_VID:    if (vid_done_i)   sq_q <= SQ_UP_RATIO;
        SQ_UP_RATIO: begin
          if (ratio_done_i) begin
            sq_q  <= SQ_IDLE;
            ext_q <= 1'b0;
          end
        end
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  assign vid_req_o   = (sq_q == SQ_LOW_VID)   || (sq_q == SQ_UP_VID);
  assign ratio_req_o = (sq_q == SQ_LOW_RATIO) || (sq_q == SQ_UP_RATIO);
  assign vid_val_o   = (sq_q == SQ_UP_VID)   ? sv_vid_q   : min_vid_i;
  assign ratio_val_o = (sq_q == SQ_UP_RATIO) ? sv_ratio_q : min_ratio_i;
  assign busy_o      = (sq_q != SQ_IDLE);
  assign ext_o       = ext_q;
  assign exit_done_o = (sq_q == SQ_UP_RATIO) && ratio_done_i;

  p_vid_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_req_o && !vid_done_i && !abort_i) |=> vid_req_o);
  p_ratio_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_req_o && !ratio_done_i && !abort_i) |=> ratio_req_o);
  // lowering: voltage step only after ratio step completed
  p_lower_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_q == SQ_LOW_VID && $past(sq_q) != SQ_LOW_VID) |-> $past(ratio_done_i));
  p_one_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vid_req_o, ratio_req_o}));
endmodule

// File: rtl/pwr_state_fsm.sv
`timescale 1ns/1ps
module pwr_state_fsm
  import pwr_state_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    soft_rst_i,
  input  logic    halt_req_i,
  input  logic    stpclk_ni,
  input  logic    snp_req_i,
  input  logic    snp_done_i,
  input  logic    brk_now_i,
  input  logic    ext_ok_i,
  input  logic    seq_busy_i,
  input  logic    seq_ext_i,
  input  logic    exit_done_i,
  output pstate_e state_o,
  output logic    halt_cyc_o,
  output logic    start_ent_o,
  output logic    start_exit_o,
  output logic    arm_o,
  output logic    clr_o
);
  pstate_e st_q, st_d;
  logic    from_halt_q, from_halt_d;
  logic    hc_q;
  logic    ent, ext_exit, clr;

  always_comb begin
    st_d        = st_q;
    from_halt_d = from_halt_q;
    ent         = 1'b0;
    ext_exit    = 1'b0;
    clr         = 1'b0;
    unique case (st_q)
      PS_RUN: begin
        if (!stpclk_ni) begin
          st_d        = PS_SGNT;
          from_halt_d = 1'b0;
        end else if (halt_req_i) begin
          st_d = PS_HALT;
          ent  = ext_ok_i;
        end
      end
      PS_HALT: begin
        if (snp_req_i) begin
          st_d = PS_HALT_SNP;
        end else if (!stpclk_ni) begin
          st_d        = PS_SGNT;
          from_halt_d = 1'b1;
        end else if (brk_now_i && !seq_busy_i) begin
          clr = 1'b1;
          if (seq_ext_i) begin
            st_d     = PS_RESTORE;
            ext_exit = 1'b1;
          end else begin
            st_d = PS_RUN;
          end
        end
      end
      PS_HALT_SNP: if (snp_done_i) st_d = PS_HALT;
      PS_SGNT: begin
        if (snp_req_i)     st_d = PS_SGNT_SNP;
        else if (stpclk_ni) st_d = from_halt_q ? PS_HALT : PS_RUN;
      end
      PS_SGNT_SNP: if (snp_done_i) st_d = PS_SGNT;
      PS_RESTORE:  if (exit_done_i) st_d = PS_RUN;
      default:     st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= PS_RUN;
      from_halt_q <= 1'b0;
      hc_q        <= 1'b0;
    end else if (soft_rst_i) begin
      st_q        <= PS_RUN;
      from_halt_q <= 1'b0;
      hc_q        <= 1'b0;
    end else begin
      st_q        <= st_d;
      from_halt_q <= from_halt_d;
      hc_q        <= (st_q == PS_RUN) && (st_d == PS_HALT);
    end
  end

  assign state_o      = st_q;
  assign halt_cyc_o   = hc_q;
  assign start_ent_o  = ent & ~soft_rst_i;
  assign start_exit_o = ext_exit & ~soft_rst_i;
  assign arm_o        = (st_q == PS_HALT) || (st_q == PS_HALT_SNP);
  assign clr_o        = clr;

  p_halt_cyc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_cyc_o |-> (st_q == PS_HALT) && ($past(st_q) == PS_RUN));
  p_snp_return_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == PS_HALT_SNP && st_q != PS_HALT_SNP && !$past(soft_rst_i))
      |-> st_q == PS_HALT);
  p_sgnt_snp_return_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == PS_SGNT_SNP && st_q != PS_SGNT_SNP && !$past(soft_rst_i))
      |-> st_q == PS_SGNT);
  p_soft_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (st_q == PS_RUN) && !halt_cyc_o);
  p_restore_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == PS_RESTORE && st_q == PS_RUN)
      |-> $past(exit_done_i || soft_rst_i));
endmodule

// File: rtl/pwr_stopclk_ctrl.sv
`timescale 1ns/1ps
module pwr_stopclk_ctrl
  import pwr_state_pkg::*;
#(
  parameter int unsigned BRK_W   = 6,
  parameter int unsigned VID_W   = 8,
  parameter int unsigned RATIO_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               ext_halt_en_i,
  input  logic               halt_req_i,
  input  logic               stpclk_ni,
  input  logic               snp_req_i,
  input  logic               snp_done_i,
  input  logic [BRK_W-1:0]   brk_i,
  input  logic [VID_W-1:0]   cur_vid_i,
  input  logic [RATIO_W-1:0] cur_ratio_i,
  input  logic [VID_W-1:0]   min_vid_i,
  input  logic [RATIO_W-1:0] min_ratio_i,
  input  logic               vid_done_i,
  input  logic               ratio_done_i,
  output logic [2:0]         state_o,
  output logic               halt_cyc_o,
  output logic               snoop_svc_o,
  output logic               vid_req_o,
  output logic [VID_W-1:0]   vid_val_o,
  output logic               ratio_req_o,
  output logic [RATIO_W-1:0] ratio_val_o
);
  pstate_e st;
  logic    brk_now, arm, clr;
  logic    start_ent, start_exit;
  logic    seq_busy, seq_ext, exit_done;
  logic    ext_ok;

  assign ext_ok = ext_halt_en_i && (cur_ratio_i != min_ratio_i);

  pwr_brk_track #(.BRK_W(BRK_W)) u_brk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .brk_i      (brk_i),
    .arm_i      (arm),
    .clr_i      (clr),
    .brk_now_o  (brk_now)
  );

  pwr_state_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .halt_req_i   (halt_req_i),
    .stpclk_ni    (stpclk_ni),
    .snp_req_i    (snp_req_i),
    .snp_done_i   (snp_done_i),
    .brk_now_i    (brk_now),
    .ext_ok_i     (ext_ok),
    .seq_busy_i   (seq_busy),
    .seq_ext_i    (seq_ext),
    .exit_done_i  (exit_done),
    .state_o      (st),
    .halt_cyc_o   (halt_cyc_o),
    .start_ent_o  (start_ent),
    .start_exit_o (start_exit),
    .arm_o        (arm),
    .clr_o        (clr)
  );

  pwr_seq #(.VID_W(VID_W), .RATIO_W(RATIO_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .abort_i      (soft_rst_i),
    .start_ent_i  (start_ent),
    .start_exit_i (start_exit),
    .cur_vid_i    (cur_vid_i),
    .cur_ratio_i  (cur_ratio_i),
    .min_vid_i    (min_vid_i),
    .min_ratio_i  (min_ratio_i),
    .vid_done_i   (vid_done_i),
    .ratio_done_i (ratio_done_i),
    .vid_req_o    (vid_req_o),
    .vid_val_o    (vid_val_o),
    .ratio_req_o  (ratio_req_o),
    .ratio_val_o  (ratio_val_o),
    .busy_o       (seq_busy),
    .ext_o        (seq_ext),
    .exit_done_o  (exit_done)
  );

  assign state_o     = st;
  assign snoop_svc_o = (st == PS_HALT_SNP) || (st == PS_SGNT_SNP);

  // restore: ratio step may only start after the voltage step finished
  p_exit_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == PS_RESTORE && $rose(ratio_req_o)) |-> $past(vid_req_o && vid_done_i));
  p_no_req_in_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == PS_RUN && $past(st) == PS_RUN) |-> !vid_req_o && !ratio_req_o);
  p_svc_only_snoop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_svc_o |-> $past(snp_req_i) || $past(snoop_svc_o));
endmodule

// File: tb/pwr_stopclk_ctrl_test.sv
`timescale 1ns/1ps
module pwr_stopclk_ctrl_test;
  localparam int BRK_W = 6;
  localparam int VID_W = 8;
  localparam int RATIO_W = 6;
  localparam int NV = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, ext_en = 0, halt_req = 0, stpclk_n = 1, snp_req = 0, snp_done = 0;
  logic [BRK_W-1:0] brk = '0;
  logic [VID_W-1:0] cur_vid = 8'h5C, min_vid = 8'h20;
  logic [RATIO_W-1:0] cur_ratio = 6'd12, min_ratio = 6'd6;
  logic vid_done = 0, ratio_done = 0;
  logic [2:0] state;
  logic halt_cyc, snoop_svc, vid_req, ratio_req;
  logic [VID_W-1:0] vid_val;
  logic [RATIO_W-1:0] ratio_val;
  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  pwr_stopclk_ctrl #(.BRK_W(BRK_W), .VID_W(VID_W), .RATIO_W(RATIO_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .ext_halt_en_i(ext_en),
    .halt_req_i(halt_req), .stpclk_ni(stpclk_n), .snp_req_i(snp_req), .snp_done_i(snp_done),
    .brk_i(brk), .cur_vid_i(cur_vid), .cur_ratio_i(cur_ratio), .min_vid_i(min_vid),
    .min_ratio_i(min_ratio), .vid_done_i(vid_done), .ratio_done_i(ratio_done),
    .state_o(state), .halt_cyc_o(halt_cyc), .snoop_svc_o(snoop_svc), .vid_req_o(vid_req),
    .vid_val_o(vid_val), .ratio_req_o(ratio_req), .ratio_val_o(ratio_val));

  // in: ext halt stpn snpr snpd brk vd rd | out: state[3] hc ss vq rq 0
  localparam logic [15:0] VEC [NV] = '{
    16'b0110_0000_0011_0000, // R2 halt, halt cycle strobe
    16'b0010_0000_0010_0000, // R2 strobe one cycle
    16'b0011_0000_0100_1000, // R4 snoop in halt
    16'b0010_0000_0100_1000, // R4 wait
    16'b0010_1000_0010_0000, // R4 back to halt
    16'b0010_0100_0000_0000, // R6 break ends plain halt
    16'b0000_0000_0110_0000, // R3 stop-grant
    16'b0000_0100_0110_0000, // R6 break ignored in stop-grant
    16'b0001_0000_1000_1000, // R5 snoop in stop-grant
    16'b0000_1000_0110_0000, // R5 back
    16'b0010_0000_0000_0000, // R3 release to normal
    16'b0110_0000_0011_0000, // R2
    16'b0000_0000_0110_0000, // R7 halt to stop-grant
    16'b0010_0000_0010_0000, // R7 back to halt
    16'b0011_0100_0100_1000, // R8 snoop and break together
    16'b0010_1000_0010_0000, // R8 back to halt
    16'b0010_0000_0000_0000, // R8 held break acted
    16'b0100_0000_0110_0000, // R3 stop-clock beats halt
    16'b0010_0000_0000_0000, // R3
    16'b1110_0000_0011_0010, // R9 ratio lowered first
    16'b1010_0000_0010_0010, // R12 held
    16'b1010_0001_0010_0100, // R9 then voltage
    16'b1010_0100_0010_0100, // R13 break while lowering
    16'b1010_0010_0010_0000, // R13 still halt
    16'b1010_0000_1010_0100, // R10 restoring, voltage first
    16'b1010_0000_1010_0100, // R12 held
    16'b1010_0010_1010_0010, // R10 ratio second
    16'b1010_0001_0000_0000  // R10 normal
  };
  localparam int VREQ [NV] = '{2,2,4,4,4,6,3,6,5,5,3,2,7,7,8,8,8,3,3,9,12,9,13,13,10,12,10,10};

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    ext_en = v[7]; halt_req = v[6]; stpclk_n = v[5]; snp_req = v[4];
    snp_done = v[3]; brk = {5'b0, v[2]}; vid_done = v[1]; ratio_done = v[0];
  endtask

  task automatic step(input logic [7:0] v);
    drive(v);
    @(negedge clk);
  endtask

  function automatic logic [7:0] outs();
    return {state, halt_cyc, snoop_svc, vid_req, ratio_req, 1'b0};
  endfunction

  initial begin
    #800000;
    nbad++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    drive(8'b0010_0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {24'b0, outs()}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15:8]);
      chk($sformatf("R%0d vector %0d", VREQ[i], i), {24'b0, outs()}, {24'b0, VEC[i][7:0]});
    end

    // R9 / R10 values, other break line
    step(8'b1110_0000);
    chk("R9 ratio target", {26'b0, ratio_val}, 32'd6);
    step(8'b1010_0001);
    chk("R9 vid target", {24'b0, vid_val}, 32'h20);
    step(8'b1010_0010);
    drive(8'b1010_0000); brk = 6'b100000; @(negedge clk);
    chk("R10 restoring", {29'b0, state}, 32'd5);
    chk("R10 saved vid", {24'b0, vid_val}, 32'h5C);
    step(8'b1010_0010);
    chk("R10 saved ratio", {26'b0, ratio_val}, 32'd12);
    chk("R10 vid released", {31'b0, vid_req}, 32'd0);
    step(8'b1010_0001);
    chk("R10 done", {29'b0, state}, 32'd0);

    // R11 already at minimum ratio
    cur_ratio = 6'd6;
    step(8'b1110_0000);
    chk("R11 plain halt", {24'b0, outs()}, 32'h30);
    step(8'b1010_0000);
    chk("R11 no request", {30'b0, vid_req, ratio_req}, 32'd0);
    step(8'b1010_0100);
    chk("R11 direct exit", {29'b0, state}, 32'd0);
    cur_ratio = 6'd12;

    // R1 soft reset during restore
    step(8'b1110_0000);
    step(8'b1010_0001);
    step(8'b1010_0010);
    step(8'b1010_0100);
    chk("R1 in restore", {24'b0, outs()}, 32'hA4);
    soft_rst = 1'b1;
    step(8'b1010_0000);
    soft_rst = 1'b0;
    chk("R1 soft reset", {24'b0, outs()}, 32'h0);
    step(8'b1010_0000);
    chk("R1 stays aborted", {24'b0, outs()}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule